// File: doc/BRIEF.md
# DMA Channel Trigger Sequencer

This block holds the global trigger register and the per-channel control state for a group of DMA channels (six by default). Software starts a channel by writing its trigger bit into a write-only global register. It forces a channel back to its first descriptor by writing the matching retrigger bit. Each channel also has a control register with an enable bit and a pause bit, plus a descriptor start address split into a 16-bit upper extension and a 32-bit lower word. From this state the block raises a start-permitted flag for each channel. For a channel picked on the fetch port, it also gives the address of the descriptor the fetch engine must read next.

The fetch engine sends an accepted request for a channel, then later reports on that descriptor: the next-descriptor address it found, and whether the descriptor was the last one or ended in an error. Each channel runs a two-state chain machine:
- `CH_FINISHED`: the next fetch uses the start address. This is the state after reset.
- `CH_RUNNING`: the next fetch uses the stored next-descriptor address.

The transitions are:
- START_CHAIN moves `CH_FINISHED` to `CH_RUNNING` on an accepted fetch.
- END_CHAIN moves `CH_RUNNING` to `CH_FINISHED` on a report that flags last or error.
- CONTINUE keeps `CH_RUNNING` on a report with neither flag, storing the next address.

A pending retrigger overrides the stored address for one accepted fetch and is consumed by it.

Top module: `dma_trig_seq`

## Requirements
- R1: After reset every trigger and retrigger bit is clear, every control register and start address reads 0, `start_ok` is all zero, and every channel is in `CH_FINISHED`.
- R2: A write with `wr_sel`=0 (global) ORs data bits [11:0] into the stored trigger state and never clears a bit. Data bits 31:12 have no effect. A read with `rd_sel`=0 always returns 0.
- R3: In the global register, data bit k (k=0..5) sets the trigger of channel k, and data bit 6+k sets the retrigger of channel k.
- R4: A write with `wr_sel`=1 (control) to channel c stores data bits [29:0] (read back zero-extended) and clears the trigger of channel c only.
- R5: `start_ok[c]` is 1 exactly when channel c is triggered, control bit 0 (enable) is 1, and control bit 1 (pause) is 0.
- R6: `wr_sel`=2 stores data bits [15:0] as the start-address extension, and `wr_sel`=3 stores all 32 bits as the lower start address. The start address is {extension, lower} (48 bits).
- R7: `fetch_addr` for channel `fetch_ch` is the start address when that channel is in `CH_FINISHED` or has a retrigger pending. Otherwise it is the channel's stored next-descriptor address.
- R8: A fetch request is accepted only when `start_ok[fetch_ch]` is 1. An accepted request clears that channel's retrigger. A request that is not accepted changes no state.
- R9: An accepted fetch moves `CH_FINISHED` to `CH_RUNNING`. A descriptor report (`desc_valid`) always stores `desc_next` for `desc_ch`. If the report has `desc_last` or `desc_err` set, it moves the channel to `CH_FINISHED`.
- R10: A trigger bit stays set across fetches and descriptor reports. Only a control write to its channel clears it.
- R11: A global write that sets a retrigger bit in the same cycle as a fetch consuming that bit leaves the retrigger pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 global, 1 control, 2 start extension, 3 start lower |
| wr_ch | input | 3 | Channel of a per-channel write |
| wr_data | input | 32 | Write data |
| rd_sel | input | 2 | Read target, same encoding as `wr_sel` |
| rd_ch | input | 3 | Channel of a per-channel read |
| rd_data | output | 32 | Combinational read data |
| fetch_req | input | 1 | Fetch engine asks to fetch for `fetch_ch` |
| fetch_ch | input | 3 | Channel on the fetch port |
| fetch_addr | output | 48 | Descriptor address selected for `fetch_ch` |
| desc_valid | input | 1 | Descriptor report strobe |
| desc_ch | input | 3 | Channel of the report |
| desc_last | input | 1 | Reported descriptor ends the chain |
| desc_err | input | 1 | Reported descriptor failed |
| desc_next | input | 48 | Next-descriptor address from the report |
| start_ok | output | 6 | Per-channel start-permitted flags |

## Verification
The bench sweeps all four enable/pause combinations on every channel. It checks that only the written channel loses its trigger: a design that cleared the whole trigger field on any control write would drop the other five flags. It walks one channel through every chain transition. A design that left a retrigger pending after use would keep returning the start address, and a design that cleared it on a refused request would lose the restart. A global write in the same cycle as a consuming fetch must leave the new retrigger set. An update with the wrong priority would drop it and return the next address instead.

// File: rtl/dts_pkg.sv
package dts_pkg;

    typedef enum logic [1:0] {
        SEL_GLOBAL    = 2'd0,
        SEL_CTRL      = 2'd1,
        SEL_START_EXT = 2'd2,
        SEL_START_LO  = 2'd3
    } reg_sel_e;

    typedef enum logic {
        CH_FINISHED = 1'b0,
        CH_RUNNING  = 1'b1
    } chain_state_e;

endpackage

// File: rtl/dts_global_reg.sv
module dts_global_reg #(
    parameter int NUM_CH = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              glob_we,
    input  logic [2*NUM_CH-1:0] glob_data,
    input  logic [NUM_CH-1:0] ctrl_we,
    input  logic [NUM_CH-1:0] retrig_take,
    output logic [NUM_CH-1:0] trig_q,
    output logic [NUM_CH-1:0] retrig_q
);

    logic [NUM_CH-1:0] trig_set;
    logic [NUM_CH-1:0] retrig_set;

    always_comb begin
        trig_set   = glob_we ? glob_data[NUM_CH-1:0]        : '0;
        retrig_set = glob_we ? glob_data[2*NUM_CH-1:NUM_CH] : '0;
    end

    // A new set wins over a clear in the same cycle.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trig_q   <= '0;
            retrig_q <= '0;
        end else begin
            trig_q   <= (trig_q & ~ctrl_we) | trig_set;
            retrig_q <= (retrig_q & ~retrig_take) | retrig_set;
        end
    end

endmodule

// File: rtl/dts_channel.sv
module dts_channel
    import dts_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int EXT_W  = 16,
    parameter int LO_W   = 32,
    parameter int CTRL_W = 30,
    localparam int ADDR_W = EXT_W + LO_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_we,
    input  logic              ext_we,
    input  logic              lo_we,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              trig,
    input  logic              retrig,
    input  logic              fetch_req,
    input  logic              desc_valid,
    input  logic              desc_end,
    input  logic [ADDR_W-1:0] desc_next,
    output logic              start_ok,
    output logic              retrig_take,
    output logic [ADDR_W-1:0] fetch_addr,
    output logic [CTRL_W-1:0] ctrl_q,
    output logic [EXT_W-1:0]  ext_q,
    output logic [LO_W-1:0]   lo_q
);

    chain_state_e      state_q, state_n;
    logic [ADDR_W-1:0] next_q;
    logic              go;

    // Configuration and next-address storage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            ext_q  <= '0;
            lo_q   <= '0;
            next_q <= '0;
        end else begin
            if (ctrl_we)    ctrl_q <= wr_data[CTRL_W-1:0];
            if (ext_we)     ext_q  <= wr_data[EXT_W-1:0];
            if (lo_we)      lo_q   <= wr_data[LO_W-1:0];
            if (desc_valid) next_q <= desc_next;
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CH_FINISHED;
        else        state_q <= state_n;
    end

    // Next state
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            CH_FINISHED: if (go)                    state_n = CH_RUNNING;
            CH_RUNNING:  if (desc_valid && desc_end) state_n = CH_FINISHED;
            default:                                state_n = CH_FINISHED;
        endcase
    end

    // Outputs
    always_comb begin
        start_ok    = trig && ctrl_q[0] && !ctrl_q[1];
        go          = fetch_req && start_ok;
        retrig_take = go && retrig;
        fetch_addr  = ((state_q == CH_FINISHED) || retrig) ? {ext_q, lo_q} : next_q;
    end

endmodule

// File: rtl/dma_trig_seq.sv
module dma_trig_seq
    import dts_pkg::*;
#(
    parameter int NUM_CH = 6,
    parameter int DATA_W = 32,
    parameter int EXT_W  = 16,
    parameter int LO_W   = 32,
    parameter int CTRL_W = 30,
    localparam int CH_W   = $clog2(NUM_CH),
    localparam int ADDR_W = EXT_W + LO_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [CH_W-1:0]   wr_ch,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [1:0]        rd_sel,
    input  logic [CH_W-1:0]   rd_ch,
    output logic [DATA_W-1:0] rd_data,
    input  logic              fetch_req,
    input  logic [CH_W-1:0]   fetch_ch,
    output logic [ADDR_W-1:0] fetch_addr,
    input  logic              desc_valid,
    input  logic [CH_W-1:0]   desc_ch,
    input  logic              desc_last,
    input  logic              desc_err,
    input  logic [ADDR_W-1:0] desc_next,
    output logic [NUM_CH-1:0] start_ok
);

    reg_sel_e          wsel, rsel;
    logic              glob_we;
    logic [NUM_CH-1:0] ctrl_we, ext_we, lo_we, ch_fetch, ch_desc;
    logic [NUM_CH-1:0] trig_q, retrig_q, retrig_take;
    logic [ADDR_W-1:0] addr_arr [NUM_CH];
    logic [CTRL_W-1:0] ctrl_arr [NUM_CH];
    logic [EXT_W-1:0]  ext_arr  [NUM_CH];
    logic [LO_W-1:0]   lo_arr   [NUM_CH];

    assign wsel    = reg_sel_e'(wr_sel);
    assign rsel    = reg_sel_e'(rd_sel);
    assign glob_we = wr_en && (wsel == SEL_GLOBAL);

    dts_global_reg #(.NUM_CH(NUM_CH)) u_glob (
        .clk        (clk),
        .rst_n      (rst_n),
        .glob_we    (glob_we),
        .glob_data  (wr_data[2*NUM_CH-1:0]),
        .ctrl_we    (ctrl_we),
        .retrig_take(retrig_take),
        .trig_q     (trig_q),
        .retrig_q   (retrig_q)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        always_comb begin
            ctrl_we[c]  = wr_en && (wsel == SEL_CTRL)      && (wr_ch == CH_W'(c));
            ext_we[c]   = wr_en && (wsel == SEL_START_EXT) && (wr_ch == CH_W'(c));
            lo_we[c]    = wr_en && (wsel == SEL_START_LO)  && (wr_ch == CH_W'(c));
            ch_fetch[c] = fetch_req  && (fetch_ch == CH_W'(c));
            ch_desc[c]  = desc_valid && (desc_ch  == CH_W'(c));
        end

        dts_channel #(
            .DATA_W(DATA_W), .EXT_W(EXT_W), .LO_W(LO_W), .CTRL_W(CTRL_W)
        ) u_chan (
            .clk        (clk),
            .rst_n      (rst_n),
            .ctrl_we    (ctrl_we[c]),
            .ext_we     (ext_we[c]),
            .lo_we      (lo_we[c]),
            .wr_data    (wr_data),
            .trig       (trig_q[c]),
            .retrig     (retrig_q[c]),
            .fetch_req  (ch_fetch[c]),
            .desc_valid (ch_desc[c]),
            .desc_end   (desc_last || desc_err),
            .desc_next  (desc_next),
            .start_ok   (start_ok[c]),
            .retrig_take(retrig_take[c]),
            .fetch_addr (addr_arr[c]),
            .ctrl_q     (ctrl_arr[c]),
            .ext_q      (ext_arr[c]),
            .lo_q       (lo_arr[c])
        );
    end

    // Fetch address and read mux
    always_comb begin
        fetch_addr = '0;
        rd_data    = '0;
        if (32'(fetch_ch) < NUM_CH) fetch_addr = addr_arr[fetch_ch];
        if (32'(rd_ch) < NUM_CH) begin
            unique case (rsel)
                SEL_GLOBAL:    rd_data = '0;
                SEL_CTRL:      rd_data = DATA_W'(ctrl_arr[rd_ch]);
                SEL_START_EXT: rd_data = DATA_W'(ext_arr[rd_ch]);
                SEL_START_LO:  rd_data = DATA_W'(lo_arr[rd_ch]);
                default:       rd_data = '0;
            endcase
        end
    end

endmodule

// File: rtl/dts_checker.sv
module dts_checker #(
    parameter int NUM_CH = 6,
    parameter int DATA_W = 32,
    localparam int CH_W = $clog2(NUM_CH)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [1:0]        wr_sel,
    input logic [CH_W-1:0]   wr_ch,
    input logic [1:0]        rd_sel,
    input logic [DATA_W-1:0] rd_data,
    input logic              fetch_req,
    input logic [CH_W-1:0]   fetch_ch,
    input logic [NUM_CH-1:0] start_ok,
    input logic [NUM_CH-1:0] trig_q,
    input logic [NUM_CH-1:0] retrig_q
);

    a_r2_global_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_sel == 2'd0) |-> (rd_data == '0));

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
        a_r4_ctrl_clears_trigger: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_sel == 2'd1 && wr_ch == CH_W'(c)) |=> !trig_q[c]);

        a_r10_trigger_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(trig_q[c]) |-> $past(wr_en && wr_sel == 2'd1 && wr_ch == CH_W'(c)));

        a_r8_retrig_consumed: assert property (@(posedge clk) disable iff (!rst_n)
            (fetch_req && fetch_ch == CH_W'(c) && start_ok[c] && retrig_q[c]
             && !(wr_en && wr_sel == 2'd0)) |=> !retrig_q[c]);

        a_r5_start_needs_trigger: assert property (@(posedge clk) disable iff (!rst_n)
            start_ok[c] |-> trig_q[c]);
    end

endmodule

bind dma_trig_seq dts_checker #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_sel   (wr_sel),
    .wr_ch    (wr_ch),
    .rd_sel   (rd_sel),
    .rd_data  (rd_data),
    .fetch_req(fetch_req),
    .fetch_ch (fetch_ch),
    .start_ok (start_ok),
    .trig_q   (trig_q),
    .retrig_q (retrig_q)
);

// File: tb/dma_trig_seq_test.sv
module dma_trig_seq_test;

    localparam int CLK_P = 10;
    localparam int NCH   = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = '0;
    logic [2:0]  wr_ch = '0;
    logic [31:0] wr_data = '0;
    logic [1:0]  rd_sel = '0;
    logic [2:0]  rd_ch = '0;
    logic [31:0] rd_data;
    logic        fetch_req = 1'b0;
    logic [2:0]  fetch_ch = '0;
    logic [47:0] fetch_addr;
    logic        desc_valid = 1'b0;
    logic [2:0]  desc_ch = '0;
    logic        desc_last = 1'b0;
    logic        desc_err = 1'b0;
    logic [47:0] desc_next = '0;
    logic [5:0]  start_ok;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    dma_trig_seq uut (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_ch(wr_ch), .wr_data(wr_data),
        .rd_sel(rd_sel), .rd_ch(rd_ch), .rd_data(rd_data),
        .fetch_req(fetch_req), .fetch_ch(fetch_ch), .fetch_addr(fetch_addr),
        .desc_valid(desc_valid), .desc_ch(desc_ch), .desc_last(desc_last),
        .desc_err(desc_err), .desc_next(desc_next), .start_ok(start_ok)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input int ch, input logic [31:0] d);
        wr_en = 1'b1; wr_sel = sel; wr_ch = 3'(ch); wr_data = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] sel, input int ch, input string req, input logic [31:0] exp);
        rd_sel = sel; rd_ch = 3'(ch);
        #1;
        check(req, 64'(rd_data), 64'(exp));
    endtask

    task automatic fetch(input int ch);
        fetch_req = 1'b1; fetch_ch = 3'(ch);
        @(posedge clk); #1;
        fetch_req = 1'b0;
    endtask

    task automatic report(input int ch, input logic [47:0] nxt, input logic lst, input logic er);
        desc_valid = 1'b1; desc_ch = 3'(ch); desc_next = nxt; desc_last = lst; desc_err = er;
        @(posedge clk); #1;
        desc_valid = 1'b0; desc_last = 1'b0; desc_err = 1'b0;
    endtask

    task automatic chk_addr(input int ch, input string req, input logic [47:0] exp);
        fetch_ch = 3'(ch);
        #1;
        check(req, 64'(fetch_addr), 64'(exp));
    endtask

    function automatic logic [47:0] start_of(input int ch);
        return {16'(ch + 1), 32'h1000_0011 + 32'(ch) * 32'h100};
    endfunction

    initial begin
        #(CLK_P * 20000);
        if (!done) begin
            n_bad++;
            n_vec++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        logic [47:0] n1, n2, n3, n4, n5;
        n1 = 48'h5555_0000_1230; n2 = 48'h0123_4567_89A0;
        n3 = 48'hBEEF_0000_0040; n4 = 48'h7777_CAFE_0100; n5 = 48'h0042_0000_0F00;

        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        #1 check("R1 start_ok", 64'(start_ok), 64'h0);
        for (int c = 0; c < NCH; c++) begin
            rd(2'd1, c, "R1 ctrl", 32'h0);
            rd(2'd2, c, "R1 ext", 32'h0);
            rd(2'd3, c, "R1 lo", 32'h0);
            chk_addr(c, "R1 finished uses start", 48'h0);
        end

        // R6 start address regs, R7 finished selects start
        for (int c = 0; c < NCH; c++) begin
            wr(2'd2, c, 32'hABCD_0000 | 32'(c + 1));
            wr(2'd3, c, 32'h1000_0011 + 32'(c) * 32'h100);
            rd(2'd2, c, "R6 ext low 16", 32'(c + 1));
            rd(2'd3, c, "R6 lo", 32'h1000_0011 + 32'(c) * 32'h100);
            chk_addr(c, "R6 R7 start addr", start_of(c));
        end

        // R5 enable/pause sweep, R4 30-bit storage
        for (int c = 0; c < NCH; c++) begin
            for (int v = 0; v < 4; v++) begin
                wr(2'd1, c, 32'hFFFF_FFFC | 32'(v));
                rd(2'd1, c, "R4 ctrl 30 bits", 32'h3FFF_FFFC | 32'(v));
                check("R4 ctrl clears trigger", 64'(start_ok), 64'h0);
                wr(2'd0, 0, 32'h1 << c);
                check("R5 start_ok", 64'(start_ok), (v == 1) ? (64'h1 << c) : 64'h0);
            end
        end
        for (int c = 0; c < NCH; c++) wr(2'd1, c, 32'h1);
        check("R4 triggers cleared", 64'(start_ok), 64'h0);

        // R2 upper bits ignored, reads zero
        wr(2'd0, 0, 32'hFFFF_F000);
        check("R2 upper bits ignored", 64'(start_ok), 64'h0);
        for (int c = 0; c < NCH; c++) chk_addr(c, "R2 no retrigger", start_of(c));
        rd(2'd0, 0, "R2 global reads zero", 32'h0);
        wr(2'd0, 0, 32'h0000_003F);
        check("R3 trigger bits", 64'(start_ok), 64'h3F);
        rd(2'd0, 3, "R2 global reads zero after set", 32'h0);
        wr(2'd0, 0, 32'h0000_0001);
        check("R2 OR keeps bits", 64'(start_ok), 64'h3F);
        wr(2'd1, 2, 32'h1);
        check("R4 only own trigger", 64'(start_ok), 64'h3B);

        // Chain on channel 3
        fetch(3);
        report(3, n1, 1'b0, 1'b0);
        chk_addr(3, "R9 continue uses next", n1);
        fetch(3);
        chk_addr(3, "R7 running uses next", n1);
        wr(2'd0, 0, 32'h1 << 9);
        chk_addr(3, "R3 R7 retrigger selects start", start_of(3));
        chk_addr(4, "R3 retrigger only ch3", start_of(4));
        fetch(3);
        chk_addr(3, "R8 retrigger consumed", n1);
        check("R10 trigger sticky", 64'(start_ok[3]), 64'h1);
        report(3, n2, 1'b1, 1'b0);
        chk_addr(3, "R9 last ends chain", start_of(3));
        fetch(3);
        chk_addr(3, "R9 restart running", n2);
        report(3, n3, 1'b0, 1'b1);
        chk_addr(3, "R9 error ends chain", start_of(3));
        check("R10 trigger sticky after report", 64'(start_ok[3]), 64'h1);

        // R8 refused fetch changes nothing
        fetch(3);
        report(3, n4, 1'b0, 1'b0);
        chk_addr(3, "R9 next stored", n4);
        wr(2'd1, 3, 32'h1);
        check("R4 ch3 trigger cleared", 64'(start_ok), 64'h33);
        wr(2'd0, 0, 32'h1 << 9);
        chk_addr(3, "R7 retrigger pending", start_of(3));
        fetch(3);
        chk_addr(3, "R8 refused fetch keeps retrigger", start_of(3));
        wr(2'd0, 0, 32'h1 << 3);
        fetch(3);
        chk_addr(3, "R8 accepted fetch consumes", n4);

        // R11 set and consume in the same cycle
        fetch(4);
        report(4, n5, 1'b0, 1'b0);
        chk_addr(4, "R9 ch4 next", n5);
        wr(2'd0, 0, 32'h1 << 10);
        wr_en = 1'b1; wr_sel = 2'd0; wr_data = 32'h1 << 10;
        fetch_req = 1'b1; fetch_ch = 3'd4;
        @(posedge clk); #1;
        wr_en = 1'b0; fetch_req = 1'b0;
        chk_addr(4, "R11 new retrigger kept", start_of(4));
        fetch(4);
        chk_addr(4, "R11 later fetch consumes", n5);
        chk_addr(3, "R9 ch3 untouched by ch4", n4);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule